// File: doc/BRIEF.md
# Split Virtqueue Used Ring Completion Writer

This block hands finished buffers back to a driver by filling the used ring of a split virtqueue kept in system memory. The device datapath offers one completion at a time over a valid/ready pair. Each completion carries the head descriptor number of the finished chain and the count of bytes the device wrote into it. For every completion the block writes an 8-byte ring element into the slot chosen by its running used index. The element holds a 32-bit id and then a 32-bit length.

The ring elements are placed in memory first. A 16-bit used index write then makes them visible to the driver, so the driver never sees an index that covers an unwritten slot. Several completions can share one index write. A flush happens as soon as the input goes quiet, or when the batch reaches its limit. A one-cycle pulse carrying the published value follows every index write. The queue size is a power of two given as its base-2 logarithm, so the slot number is the index with its upper bits masked off. The index itself runs through all 65536 values and wraps freely.

Top module: `used_ring_writer`

## Requirements
- R1: The completion accepted while the running index is I goes to slot S = I mod 2^cfg_qsize_log2. Its id word is written to cfg_ring_base + 4 + 8*S, and then its length word to cfg_ring_base + 8 + 8*S, in that order.
- R2: The memory bus is 32 bits wide and little-endian: byte lane k (data bits 8k+7..8k) lands at wr_addr + k. Element words use wr_strb = 4'b1111. The id word is the head number zero-extended to 32 bits. The index write goes to the 4-byte-aligned cfg_ring_base with wr_strb = 4'b1100 and the index in wr_data[31:16], which puts its low byte at ring base + 2.
- R3: The running index is 16 bits and starts at parameter IDX_RESET. It grows by one for each completion whose element writes are done, and it wraps from 65535 to 0.
- R4: An index write is issued only after both element writes of every completion in the batch have been acknowledged. The value written equals the running index at that time.
- R5: A write request holds wr_req, wr_addr, wr_data and wr_strb steady until the cycle in which wr_ack is high. That cycle completes the write.
- R6: With at least one unpublished completion and no write in flight, the block starts the index write in the next cycle in either of two cases: cmp_valid is low, or BATCH_MAX (8) completions are unpublished. At the limit, cmp_ready stays low.
- R7: cmp_ready is high exactly when no write is in flight and fewer than BATCH_MAX completions are unpublished. An accepted completion starts its id write in the next cycle.
- R8: The cycle after the acknowledged index write, pub_valid is high for one cycle and pub_idx carries the value just written.
- R9: During reset, cmp_ready is 1 and wr_req and pub_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion accepted this cycle when valid |
| cmp_head | input | 16 | Head descriptor number of the finished chain |
| cmp_len | input | 32 | Bytes written by the device |
| cfg_ring_base | input | AW | Byte address of the used ring, 4-byte aligned |
| cfg_qsize_log2 | input | 4 | Base-2 logarithm of the queue size, 0 to 15 |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Word-aligned byte address of the write |
| wr_data | output | 32 | Write data, little-endian lanes |
| wr_strb | output | 4 | Byte enables |
| wr_ack | input | 1 | Write accepted this cycle |
| pub_valid | output | 1 | Index publish pulse |
| pub_idx | output | 16 | Index value just published |

## Verification
The bench builds the block with IDX_RESET = 16'hFFF4, BATCH_MAX = 8 and a 32-bit address. Because the index starts twelve steps below its wrap point, the 65535-to-0 rollover and the masked slot number both fall inside a run of a few dozen completions. The queue-size input is swept over 4, 1 and 32768 slots. Back-to-back streams longer than eight completions make the batch limit fire. Single completions separated by gaps cover the flush on an idle input. Write acknowledges arrive after 0 to 2 wait cycles, so the hold rule and the ordering of element writes before the index write are both exercised under stalls.

// File: rtl/used_ring_pkg.sv
package used_ring_pkg;

    typedef enum logic [1:0] {
        ST_ACCEPT = 2'd0,
        ST_ID     = 2'd1,
        ST_LEN    = 2'd2,
        ST_IDX    = 2'd3
    } ur_state_e;

    localparam int unsigned IDX_W  = 16;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned STRB_W = WORD_W / 8;

endpackage

// File: rtl/used_ring_addr.sv
module used_ring_addr
    import used_ring_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LOG_W = 4
) (
    input  logic [AW-1:0]    base,
    input  logic [LOG_W-1:0] qsize_log2,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    elem_addr
);
    localparam logic [AW-1:0] RING_OFS = AW'(4);
    localparam int unsigned   ELEM_SH  = 3;

    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] slot;

    always_comb begin
        mask      = ~({IDX_W{1'b1}} << qsize_log2);
        slot      = idx & mask;
        elem_addr = base + RING_OFS + (AW'(slot) << ELEM_SH);
    end
endmodule

// File: rtl/used_ring_wr_mux.sv
module used_ring_wr_mux
    import used_ring_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  ur_state_e         state,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     elem_addr,
    input  logic [IDX_W-1:0]  head,
    input  logic [WORD_W-1:0] len,
    input  logic [IDX_W-1:0]  idx,
    output logic              req,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] data,
    output logic [STRB_W-1:0] strb
);
    localparam logic [AW-1:0]     LEN_OFS   = AW'(4);
    localparam logic [STRB_W-1:0] STRB_FULL = '1;
    localparam logic [STRB_W-1:0] STRB_HI   = 4'b1100;

    always_comb begin
        req  = 1'b0;
        addr = '0;
        data = '0;
        strb = '0;
        unique case (state)
            ST_ID: begin
                req  = 1'b1;
                addr = elem_addr;
                data = WORD_W'(head);
                strb = STRB_FULL;
            end
            ST_LEN: begin
                req  = 1'b1;
                addr = elem_addr + LEN_OFS;
                data = len;
                strb = STRB_FULL;
            end
            ST_IDX: begin
                req  = 1'b1;
                addr = base;
                data = {idx, {(WORD_W-IDX_W){1'b0}}};
                strb = STRB_HI;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/used_ring_writer.sv
module used_ring_writer
    import used_ring_pkg::*;
#(
    parameter int unsigned      AW        = 32,
    parameter int unsigned      LOG_W     = 4,
    parameter int unsigned      BATCH_MAX = 8,
    parameter logic [15:0]      IDX_RESET = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [15:0]       cmp_head,
    input  logic [31:0]       cmp_len,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [LOG_W-1:0]  cfg_qsize_log2,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_strb,
    input  logic              wr_ack,
    output logic              pub_valid,
    output logic [15:0]       pub_idx
);
    localparam int unsigned      CNT_W     = $clog2(BATCH_MAX + 1);
    localparam logic [CNT_W-1:0] BATCH_LIM = CNT_W'(BATCH_MAX);

    typedef struct packed {
        ur_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  head;
        logic [WORD_W-1:0] len;
        logic              pub;
        logic [IDX_W-1:0]  pub_idx;
    } regs_t;

    regs_t r_d, r_q;
    logic [AW-1:0] elem_addr;

    used_ring_addr #(.AW(AW), .LOG_W(LOG_W)) u_addr (
        .base       (cfg_ring_base),
        .qsize_log2 (cfg_qsize_log2),
        .idx        (r_q.idx),
        .elem_addr  (elem_addr)
    );

    used_ring_wr_mux #(.AW(AW)) u_mux (
        .state     (r_q.st),
        .base      (cfg_ring_base),
        .elem_addr (elem_addr),
        .head      (r_q.head),
        .len       (r_q.len),
        .idx       (r_q.idx),
        .req       (wr_req),
        .addr      (wr_addr),
        .data      (wr_data),
        .strb      (wr_strb)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pub   = 1'b0;
        cmp_ready = (r_q.st == ST_ACCEPT) && (r_q.cnt != BATCH_LIM);
        unique case (r_q.st)
            ST_ACCEPT: begin
                if (cmp_valid && cmp_ready) begin
                    r_d.head = cmp_head;
                    r_d.len  = cmp_len;
                    r_d.st   = ST_ID;
                end else if (r_q.cnt != '0) begin
                    r_d.st = ST_IDX;
                end
            end
            ST_ID: begin
                if (wr_ack) r_d.st = ST_LEN;
            end
            ST_LEN: begin
                if (wr_ack) begin
                    r_d.st  = ST_ACCEPT;
                    r_d.idx = r_q.idx + 16'd1;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_IDX: begin
                if (wr_ack) begin
                    r_d.st      = ST_ACCEPT;
                    r_d.cnt     = '0;
                    r_d.pub     = 1'b1;
                    r_d.pub_idx = r_q.idx;
                end
            end
            default: r_d.st = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_ACCEPT;
            r_q.idx     <= IDX_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign pub_valid = r_q.pub;
    assign pub_idx   = r_q.pub_idx;

endmodule

// File: rtl/used_ring_writer_chk.sv
module used_ring_writer_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmp_valid,
    input logic          cmp_ready,
    input logic [AW-1:0] cfg_ring_base,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic [3:0]    wr_strb,
    input logic          wr_ack,
    input logic          pub_valid
);
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !cmp_ready);

    // R7
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> wr_req && wr_strb == 4'b1111);

    // R8
    pub_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |-> $past(wr_req && wr_ack && wr_strb == 4'b1100));

    // R8
    pub_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |=> !pub_valid);

    // R2
    idx_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_strb != 4'b1111 |-> wr_strb == 4'b1100 && wr_addr == cfg_ring_base);
endmodule

bind used_ring_writer used_ring_writer_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_valid     (cmp_valid),
    .cmp_ready     (cmp_ready),
    .cfg_ring_base (cfg_ring_base),
    .wr_req        (wr_req),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_strb       (wr_strb),
    .wr_ack        (wr_ack),
    .pub_valid     (pub_valid)
);

// File: tb/used_ring_writer_tb.sv
`timescale 1ns/1ps
module used_ring_writer_tb;
    localparam int          AW    = 32;
    localparam int          BATCH = 8;
    localparam logic [15:0] IRST  = 16'hFFF4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        cmp_ready;
    logic [15:0] cmp_head = '0;
    logic [31:0] cmp_len = '0;
    logic [31:0] cfg_ring_base = 32'h1000;
    logic [3:0]  cfg_qsize_log2 = 4'd2;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;
    logic        wr_ack = 1'b0;
    logic        pub_valid;
    logic [15:0] pub_idx;

    always #10 clk = ~clk;

    used_ring_writer #(.AW(AW), .BATCH_MAX(BATCH), .IDX_RESET(IRST)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
        .cmp_head(cmp_head), .cmp_len(cmp_len), .cfg_ring_base(cfg_ring_base),
        .cfg_qsize_log2(cfg_qsize_log2), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .wr_ack(wr_ack),
        .pub_valid(pub_valid), .pub_idx(pub_idx)
    );

    int errors = 0;
    int checks = 0;
    logic [15:0] q_head[$];
    logic [31:0] q_len[$];
    logic [15:0] m_idx = IRST;
    logic [15:0] last_pub = IRST;
    logic [15:0] pub_exp = '0;
    int  since = 0;
    bit  phase = 1'b0;
    bit  pub_pend = 1'b0;
    bit  flush_prev = 1'b0;
    bit  acc_prev = 1'b0;
    bit  run = 1'b0;
    int  waitc = 0;
    int  full_batches = 0;
    int  wraps = 0;
    int  cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Behavioural reference, compared at every falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                finish_run();
            end
            if (run) begin
                logic [31:0] e_addr, e_data;
                logic [3:0]  e_strb;
                logic [15:0] mask;
                bit dropped;
                // R7 R6 ready rule
                chk(cmp_ready == (!wr_req && since < BATCH), "R7 cmp_ready", cmp_ready, !wr_req && since < BATCH);
                // R8 publish pulse
                chk(pub_valid == pub_pend, "R8 pub_valid", pub_valid, pub_pend);
                if (pub_pend) chk(pub_idx == pub_exp, "R8 pub_idx", pub_idx, pub_exp);
                pub_pend = 1'b0;
                // R6 flush starts in the next cycle
                if (flush_prev) chk(wr_req && q_head.size() == 0 && wr_strb == 4'b1100, "R6 flush start", {wr_req, wr_strb}, 5'h1C);
                // R7 id write follows acceptance
                if (acc_prev) chk(wr_req, "R7 write start", wr_req, 1);
                dropped = 1'b0;
                if (wr_ack) begin
                    wr_ack  = 1'b0;
                    dropped = 1'b1;
                    waitc   = $urandom % 3;
                end
                if (wr_req) begin
                    mask = ~(16'hFFFF << cfg_qsize_log2);
                    if (q_head.size() != 0) begin
                        e_addr = cfg_ring_base + 32'd4 + ({16'h0, m_idx & mask} << 3) + (phase ? 32'd4 : 32'd0);
                        e_data = phase ? q_len[0] : {16'h0, q_head[0]};
                        e_strb = 4'hF;
                        // R1 R2 element write
                        chk(wr_addr == e_addr, "R1 element address", wr_addr, e_addr);
                        chk(wr_data == e_data && wr_strb == e_strb, "R2 element data", {wr_strb, wr_data}, {e_strb, e_data});
                    end else begin
                        e_data = {m_idx, 16'h0};
                        // R2 R3 R4 index write
                        chk(wr_addr == cfg_ring_base && wr_strb == 4'b1100, "R2 idx lane", {wr_strb, wr_addr}, {4'b1100, cfg_ring_base});
                        chk(wr_data[31:16] == m_idx, "R3 idx value", wr_data[31:16], m_idx);
                        chk(since >= 1 && since <= BATCH && !phase, "R4 idx after elements", since, BATCH);
                    end
                    if (!dropped) begin
                        if (waitc == 0) begin
                            wr_ack = 1'b1;
                            if (q_head.size() != 0) begin
                                if (phase) begin
                                    void'(q_head.pop_front());
                                    void'(q_len.pop_front());
                                    m_idx = m_idx + 16'd1;
                                    since++;
                                end
                                phase = !phase;
                            end else begin
                                if (since == BATCH) full_batches++;
                                if (m_idx < last_pub) wraps++;
                                last_pub = m_idx;
                                pub_exp  = m_idx;
                                pub_pend = 1'b1;
                                since    = 0;
                            end
                        end else begin
                            waitc--;
                        end
                    end
                end
                flush_prev = !wr_req && since > 0 && (!cmp_valid || since == BATCH);
                acc_prev   = cmp_valid && cmp_ready;
                if (acc_prev) begin
                    q_head.push_back(cmp_head);
                    q_len.push_back(cmp_len);
                end
            end
        end
    end

    task automatic send(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cmp_valid = 1'b1;
            cmp_head  = 16'($urandom);
            cmp_len   = $urandom;
            do @(negedge clk); while (!cmp_ready);
            if (gap > 0) begin
                @(posedge clk); #1;
                cmp_valid = 1'b0;
                repeat (gap) @(posedge clk);
            end
        end
        @(posedge clk); #1;
        cmp_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!wr_req && since == 0 && q_head.size() == 0) quiet++;
            else quiet = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cmp_ready == 1'b1, "R9 reset ready", cmp_ready, 1);
        chk(wr_req == 1'b0, "R9 reset wr_req", wr_req, 0);
        chk(pub_valid == 1'b0, "R9 reset pub", pub_valid, 0);
        rst_n = 1'b1;
        run   = 1'b1;
        // R6 idle-input flush with single completions, 4 slots
        send(3, 4);
        wait_idle();
        // R3 wrap and R6 batch limit with a long stream
        send(20, 0);
        wait_idle();
        // R1 single-slot ring
        cfg_qsize_log2 = 4'd0;
        cfg_ring_base  = 32'h2000;
        send(5, 0);
        send(2, 3);
        wait_idle();
        // R1 largest ring
        cfg_qsize_log2 = 4'd15;
        cfg_ring_base  = 32'h0001_0000;
        send(10, 0);
        wait_idle();
        // R6 batch limit reached, R3 wrap observed
        chk(full_batches >= 2, "R6 full batches", full_batches, 2);
        chk(wraps >= 1, "R3 index wrap", wraps, 1);
        chk(m_idx == 16'(IRST + 16'd40), "R3 final index", m_idx, 16'(IRST + 16'd40));
        finish_run();
    end
endmodule